// File: doc/BRIEF.md
# Dominated-Permutation Issuer for Seven-Variable Truth Tables

The block receives a pair of truth tables over `NVAR` Boolean variables, an upper function and a lower function, each packed as a `2**NVAR`-bit vector. It enumerates every reordering of the last `NTAIL` variables of the lower function, builds each reordered copy by rewiring alone, and keeps only those copies whose true points all lie inside the upper function. The kept copies leave one per cycle on a valid/ready output, tagged with their enumeration index. The final copy of a pair carries an end flag. A pair with no kept copy is absorbed without producing output and without costing an output cycle.

A fixed exchange of two leading variables is applied to the lower function before enumeration. This stands in for the outer permutation stages that feed this block. Downstream logic, such as a component counter, consumes the issued vectors.

Top module: `permfilt_iter`

## Requirements
- R1: Bit i of every vector holds the function value for the input set whose members are the set bits of i. For index p, the output equals the lower input after these exchanges, in this order: the front exchange, then variable B with B+d0, then variable B+1 with B+1+d1, then variable B+2 with B+2+d2. Here B = NVAR-NTAIL and p = d0*6 + d1*2 + d2, for NTAIL=4.
- R2: An issued vector never has a true point that the upper function lacks: (out_bot & ~upper) == 0.
- R3: Every index whose reordered copy satisfies R2 is issued exactly once, in ascending index order, one per accepted output cycle. No other index is issued.
- R4: A pair with no satisfying index produces no output, and in_ready stays high in the following cycle.
- R5: out_last is high exactly on the highest-indexed satisfying copy of a pair.
- R6: While out_valid is high and out_ready is low, out_bot, out_perm and out_last hold their values.
- R7: After reset, out_valid is low and in_ready is high.
- R8: in_ready is high when no copy is pending, or when the final copy of a pair is being accepted. In the second case the next pair's first copy is presented in the following cycle.
- R9: The front exchange swaps variables FRONT_HI and FRONT_LO (1 and 0 by default) before enumeration. With that default, a lower function true only on set {v0} yields, at index 0, a vector true only at bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_top | input | 2**NVAR | Upper (dominating) function |
| in_bot | input | 2**NVAR | Lower function to be reordered |
| out_valid | output | 1 | A dominated copy is presented |
| out_ready | input | 1 | Consumer takes the copy |
| out_bot | output | 2**NVAR | Reordered lower function |
| out_perm | output | clog2(NTAIL!) | Enumeration index of the copy |
| out_last | output | 1 | Final copy of the current pair |

## Verification
The bench builds the block at its full default size: NVAR=7, NTAIL=4, and a front exchange of variables 1 and 0. This gives 128-bit vectors and 24-slot bundles. At that size the all-24-valid bundle (empty lower function), the fully discarded bundle (empty upper function) and sparse mixtures are all reachable. The reference model reorders truth tables by remapping input indices through composed variable exchanges. It is exercised with back-to-back pairs under constant ready, and with random gaps under random back-pressure.

// File: rtl/permfilt_pkg.sv
package permfilt_pkg;

  // n! for the enumeration size
  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int k = 2; k <= n; k++) r = r * k;
    return r;
  endfunction

  // Mixed-radix digit k of enumeration index p; digit k has radix ntail-k
  function automatic int perm_digit(input int p, input int k, input int ntail);
    int rem;
    rem = p;
    for (int j = ntail - 2; j > k; j--) rem = rem / (ntail - j);
    return rem % (ntail - k);
  endfunction

endpackage

// File: rtl/permfilt_rewire.sv
module permfilt_rewire
  import permfilt_pkg::*;
#(
  parameter int NVAR     = 7,
  parameter int NTAIL    = 4,
  parameter int FRONT_HI = 1,
  parameter int FRONT_LO = 0,
  localparam int W       = 1 << NVAR,
  localparam int NPERM   = fact(NTAIL),
  localparam int BASE    = NVAR - NTAIL
) (
  input  logic [W-1:0]            src,
  output logic [NPERM-1:0][W-1:0] perms
);

  // Exchange variables hi and lo (hi >= lo): indices holding hi but not lo
  // move down by 2^hi - 2^lo, the mirror set moves up; pure wiring.
  function automatic logic [W-1:0] swap_vars(input logic [W-1:0] v,
                                             input int hi, input int lo);
    logic [W-1:0] r;
    int d;
    r = v;
    d = (1 << hi) - (1 << lo);
    if (hi != lo) begin
      for (int i = 0; i < W; i++) begin
        if (i[hi] && !i[lo]) r[i-d] = v[i];
        else if (i[lo] && !i[hi]) r[i+d] = v[i];
      end
    end
    return r;
  endfunction

  function automatic logic [W-1:0] apply_perm(input logic [W-1:0] v, input int p);
    logic [W-1:0] r;
    r = swap_vars(v, FRONT_HI, FRONT_LO);
    for (int k = 0; k < NTAIL - 1; k++)
      r = swap_vars(r, BASE + k + perm_digit(p, k, NTAIL), BASE + k);
    return r;
  endfunction

  for (genvar g = 0; g < NPERM; g++) begin : g_perm
    assign perms[g] = apply_perm(src, g);
  end

endmodule

// File: rtl/permfilt_check.sv
module permfilt_check #(
  parameter int W = 128,
  parameter int N = 24
) (
  input  logic [W-1:0]        upper,
  input  logic [N-1:0][W-1:0] cand,
  output logic [N-1:0]        ok
);

  for (genvar g = 0; g < N; g++) begin : g_ok
    assign ok[g] = ~|(cand[g] & ~upper);
  end

endmodule

// File: rtl/permfilt_pick.sv
module permfilt_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  mask,
  output logic [N-1:0]  sel_oh,
  output logic [IW-1:0] sel_idx,
  output logic          single
);

  assign sel_oh = mask & (~mask + N'(1));
  assign single = (mask != '0) && ((mask & (mask - N'(1))) == '0);

  always_comb begin
    sel_idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (mask[i]) sel_idx = IW'(i);
  end

endmodule

// File: rtl/permfilt_iter.sv
module permfilt_iter
  import permfilt_pkg::*;
#(
  parameter int NVAR     = 7,
  parameter int NTAIL    = 4,
  parameter int FRONT_HI = 1,
  parameter int FRONT_LO = 0,
  localparam int W       = 1 << NVAR,
  localparam int NPERM   = fact(NTAIL),
  localparam int PW      = (NPERM > 1) ? $clog2(NPERM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_top,
  input  logic [W-1:0]  in_bot,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_bot,
  output logic [PW-1:0] out_perm,
  output logic          out_last
);

  logic [NPERM-1:0][W-1:0] in_perms, held_perms;
  logic [NPERM-1:0]        in_mask, mask_q, sel_oh;
  logic [W-1:0]            bot_q;
  logic [PW-1:0]           sel_idx;
  logic                    single;
  logic                    in_fire, out_fire, last_fire, drop_evt;

  // Validity of every reordering, computed on the arriving pair
  permfilt_rewire #(.NVAR(NVAR), .NTAIL(NTAIL), .FRONT_HI(FRONT_HI), .FRONT_LO(FRONT_LO))
    u_rw_in (.src(in_bot), .perms(in_perms));

  permfilt_check #(.W(W), .N(NPERM))
    u_check (.upper(in_top), .cand(in_perms), .ok(in_mask));

  // Output copies rebuilt from the held lower function
  permfilt_rewire #(.NVAR(NVAR), .NTAIL(NTAIL), .FRONT_HI(FRONT_HI), .FRONT_LO(FRONT_LO))
    u_rw_out (.src(bot_q), .perms(held_perms));

  permfilt_pick #(.N(NPERM), .IW(PW))
    u_pick (.mask(mask_q), .sel_oh(sel_oh), .sel_idx(sel_idx), .single(single));

  assign out_valid = |mask_q;
  assign out_fire  = out_valid & out_ready;
  assign last_fire = out_fire & single;
  assign in_ready  = ~out_valid | last_fire;
  assign in_fire   = in_valid & in_ready;
  assign drop_evt  = in_fire & ~|in_mask;

  assign out_bot  = held_perms[sel_idx];
  assign out_perm = sel_idx;
  assign out_last = single;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      bot_q  <= '0;
    end else if (in_fire) begin
      mask_q <= in_mask;
      bot_q  <= in_bot;
    end else if (out_fire) begin
      mask_q <= mask_q & ~sel_oh;
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bot) && $stable(out_perm) && $stable(out_last));

  // R3
  perm_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && !out_last |=> out_valid && (out_perm > $past(out_perm)));

  // R3
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(sel_oh) == 1);

  // R4
  drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !out_valid && in_ready);

  // R5
  bundle_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && out_last && !in_fire |=> !out_valid);

  // R8
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && !drop_evt |=> out_valid);

endmodule

// File: tb/permfilt_iter_bench.sv
module permfilt_iter_bench;

  localparam int NV = 7;
  localparam int W  = 128;

  typedef struct {
    logic [W-1:0] v;
    logic [W-1:0] t;
    int           p;
    bit           last;
  } exp_t;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         in_valid = 0;
  logic         in_ready;
  logic [W-1:0] in_top = '0;
  logic [W-1:0] in_bot = '0;
  logic         out_valid;
  logic         out_ready = 0;
  logic [W-1:0] out_bot;
  logic [4:0]   out_perm;
  logic         out_last;

  int checks = 0;
  int failures = 0;
  int rmode = 0;
  bit done = 0;
  bit r9_pending = 0;
  bit prev_stall = 0;
  logic [W-1:0] prev_bot = '0;
  exp_t q[$];

  always #5 clk = ~clk;

  permfilt_iter #(.NVAR(7), .NTAIL(4), .FRONT_HI(1), .FRONT_LO(0)) u_permfilt_iter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_top(in_top), .in_bot(in_bot), .out_valid(out_valid), .out_ready(out_ready),
    .out_bot(out_bot), .out_perm(out_perm), .out_last(out_last));

  function automatic int xchg(input int j, input int a, input int b);
    if (((j >> a) & 1) != ((j >> b) & 1)) return j ^ ((1 << a) | (1 << b));
    return j;
  endfunction

  // Reorder by remapping input indices through composed variable exchanges
  function automatic logic [W-1:0] model_perm(input logic [W-1:0] f, input int p);
    int src[W];
    int nxt[W];
    int pa[4];
    int pb[4];
    logic [W-1:0] r;
    pa[0] = 1;        pb[0] = 0;
    pa[1] = 3 + p/6;  pb[1] = 3;
    pa[2] = 4 + (p/2)%3; pb[2] = 4;
    pa[3] = 5 + p%2;  pb[3] = 5;
    for (int j = 0; j < W; j++) src[j] = j;
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < W; j++) nxt[j] = src[xchg(j, pa[s], pb[s])];
      for (int j = 0; j < W; j++) src[j] = nxt[j];
    end
    for (int j = 0; j < W; j++) r[j] = f[src[j]];
    return r;
  endfunction

  function automatic logic [W-1:0] downclose(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int j = 0; j < W; j++)
      for (int i = 0; i < W; i++)
        if (v[i] && ((i & j) == j)) r[j] = 1'b1;
    return r;
  endfunction

  function automatic logic [W-1:0] sparse(input int k);
    logic [W-1:0] r;
    r = '0;
    for (int n = 0; n < k; n++) r[$urandom % W] = 1'b1;
    return r;
  endfunction

  task automatic push_pair(input logic [W-1:0] t, input logic [W-1:0] b);
    int added;
    exp_t e;
    added = 0;
    for (int p = 0; p < 24; p++) begin
      e.v = model_perm(b, p);
      e.t = t;
      e.p = p;
      e.last = 0;
      if ((e.v & ~t) == '0) begin
        q.push_back(e);
        added++;
      end
    end
    if (added > 0) q[q.size()-1].last = 1;
  endtask

  task automatic fail(input string msg);
    failures++;
    $display("FAIL %s", msg);
  endtask

  task automatic step(input bit v, input logic [W-1:0] t, input logic [W-1:0] b, output bit acc);
    bit exp_rdy, ofire;
    @(negedge clk);
    in_valid = v;
    in_top = t;
    in_bot = b;
    out_ready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
    #1;
    // R3 R4: output presence follows the pending list
    checks++;
    if (out_valid !== (q.size() > 0))
      fail($sformatf("R3 R4 out_valid got %0b exp %0b", out_valid, q.size() > 0));
    // R8
    exp_rdy = (q.size() == 0) || (q.size() == 1 && out_ready);
    checks++;
    if (in_ready !== exp_rdy)
      fail($sformatf("R8 in_ready got %0b exp %0b", in_ready, exp_rdy));
    if (out_valid && q.size() > 0) begin
      checks++;
      if (out_perm !== 5'(q[0].p))
        fail($sformatf("R3 out_perm got %0d exp %0d", out_perm, q[0].p));
      checks++;
      if (out_bot !== q[0].v)
        fail($sformatf("R1 out_bot got %h exp %h", out_bot, q[0].v));
      checks++;
      if ((out_bot & ~q[0].t) !== '0)
        fail($sformatf("R2 out_bot %h not inside upper %h", out_bot, q[0].t));
      checks++;
      if (out_last !== q[0].last)
        fail($sformatf("R5 out_last got %0b exp %0b", out_last, q[0].last));
    end
    if (prev_stall) begin
      checks++;
      if (!out_valid || out_bot !== prev_bot)
        fail($sformatf("R6 held data got %h exp %h", out_bot, prev_bot));
    end
    ofire = out_valid && out_ready;
    if (r9_pending && ofire) begin
      checks++;
      if (out_perm !== 5'd0 || out_bot !== 128'h4)
        fail($sformatf("R9 first copy got idx %0d %h exp idx 0 %h", out_perm, out_bot, 128'h4));
      r9_pending = 0;
    end
    prev_stall = out_valid && !out_ready;
    prev_bot = out_bot;
    acc = in_valid && in_ready;
    if (ofire && q.size() > 0) void'(q.pop_front());
    if (acc) push_pair(t, b);
  endtask

  task automatic send(input logic [W-1:0] t, input logic [W-1:0] b, input int gap);
    bit acc;
    acc = 0;
    while (!acc) step(1'b1, t, b, acc);
    for (int g = 0; g < gap; g++) step(1'b0, '0, '0, acc);
  endtask

  task automatic drain;
    bit acc;
    int n;
    n = 0;
    while (q.size() > 0 && n < 200) begin
      step(1'b0, '0, '0, acc);
      n++;
    end
    for (int g = 0; g < 3; g++) step(1'b0, '0, '0, acc);
  endtask

  initial begin
    logic [W-1:0] b, t;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1)
      fail($sformatf("R7 reset out_valid %0b in_ready %0b exp 0 1", out_valid, in_ready));
    rst_n = 1;

    // R9: lower true only on {v0}; upper all ones keeps all 24
    rmode = 0;
    r9_pending = 1;
    send({W{1'b1}}, 128'h2, 0);
    drain();

    // All 24 valid: empty lower function
    send(downclose(sparse(5)), '0, 0);
    drain();

    // R4: empty upper drops a nonempty lower, twice in a row
    send('0, downclose(sparse(2)) | 128'h1, 0);
    send('0, 128'h1, 0);
    drain();

    // Upper equal to lower
    b = downclose(sparse(3));
    send(b, b, 0);
    drain();

    // Back-to-back random pairs, constant ready
    for (int n = 0; n < 20; n++) begin
      b = downclose(sparse(1 + $urandom % 4));
      t = downclose(b | sparse(2 + $urandom % 25));
      send(t, b, 0);
    end
    drain();

    // Random gaps and back-pressure
    rmode = 1;
    for (int n = 0; n < 25; n++) begin
      b = downclose(sparse(1 + $urandom % 4));
      t = (n % 6 == 5) ? '0 : downclose(b | sparse(2 + $urandom % 25));
      send(t, b, $urandom % 3);
    end
    drain();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired got running exp finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule